// File: doc/BRIEF.md
# Random Number Generator Control and Status Registers

This block is the register front end of a hardware random number generator. A host on a simple 32-bit memory-mapped bus reads and writes five registers: control, status, data, noise-source control and health-test control. Behind the registers the block accepts 32-bit entropy words from an abstract source with a valid strobe. It holds one word until the host reads it, and it reports seed faults and clock faults.

Configuration is applied through a conditioning reset. A control write that sets the reset bit also loads the configuration fields. A later control write that clears the bit starts an internal reset of fixed length. The reset bit reads back as 1 until that reset completes, and completion clears any outstanding seed error. A seed fault the source cannot fix blocks generation until software runs this reset. A fault the source fixed by itself leaves only a sticky flag, which software clears. A lock bit freezes the configuration until system reset. A prescaler derives the entropy sampling tick from the divider exponent.

Top module: `rng_ctrl_regs`

## Requirements
- R1: After reset, control reads 0x0030_0400, and status, data, noise-control and health-control all read 0.
- R2: Offsets are control 0x00, status 0x04, data 0x08, noise control 0x0C and health control 0x10. Control bits: 2 enable, 5 clock-check disable, 19:16 divider exponent, 30 conditioning reset, 31 lock. Configuration fields are 25:8 and 5. Status bits: 0 data ready, 1 clock fault now, 2 seed fault now, 5 clock fault flag, 6 seed fault flag.
- R3: The configuration fields (bits 25:8 and 5) change only on a control write with bit 30 = 1 while unlocked. The enable bit follows every control write.
- R4: A control write with bit 30 = 1 arms the reset, and bit 30 then reads 1. A later control write with bit 30 = 0 starts it. Bit 30 reads 1 for 16 cycles after that write's edge and clears on the 16th edge. At that edge the seed fault now and seed fault flag bits clear, and data ready drops.
- R5: A seed fault pulse sets status bits 2 and 6 at the next edge and drops data ready. While bit 2 is set, no word is captured and data reads return 0.
- R6: A self-fixed seed fault pulse sets only status bit 6. Writing status with bit 6 = 0 clears it, and writing 1 leaves it unchanged.
- R7: With bit 5 of the configuration at 0, status bit 1 follows the clock-fault input one cycle later, and status bit 5 latches it. Writing 0 to status bit 5 clears the flag. With bit 5 at 1, clock faults are ignored.
- R8: A valid word is captured when enable is set, no reset is armed or running, seed fault now is clear and data ready is clear. Data ready rises at that edge. A held word is never overwritten.
- R9: A data read while data ready is set returns the held word and clears data ready. Otherwise a data read returns 0.
- R10: A control write with bit 31 = 1 sets the lock until system reset. While locked, configuration, noise-control and health-control writes are ignored, and enable stays writable.
- R11: Noise control stores only bits 17:0. Health control stores all 32 bits.
- R12: With enable set, ent_tick is high when the count of clock edges since reset, modulo 2^e, equals 2^e-1, where e is the divider exponent. With enable clear, ent_tick is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ent_valid | input | 1 | Entropy word strobe |
| ent_word | input | 32 | Entropy word |
| seed_fault | input | 1 | Seed fault needing software reset |
| seed_autofix | input | 1 | Seed fault the source already fixed |
| clk_fault | input | 1 | Entropy clock out of range |
| ent_tick | output | 1 | Entropy sampling tick |
| cond_busy | output | 1 | Conditioning reset armed or running |
| data_ready | output | 1 | A word is held |
| seed_err | output | 1 | Seed fault outstanding |

## Verification
Read data is combinational, so each read is checked in the cycle it is issued, against model state as of the previous edge. Register writes, captures and faults show up one edge later. The conditioning reset ends exactly 16 edges after the clearing write. The reference model advances on the same edges as the design, and the registered outputs are compared at every falling edge. A delay of one cycle in any flag or counter therefore surfaces as a mismatch at once.

// File: rtl/rng_cr_pkg.sv
package rng_cr_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 4;

  localparam logic [ADDR_W-1:0] OFF_CR = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_SR = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_DR = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_NS = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_HT = 5'h10;

  localparam int B_EN    = 2;
  localparam int B_CKOFF = 5;
  localparam int B_DIV   = 16;
  localparam int B_CRST  = 30;
  localparam int B_LOCK  = 31;

  localparam int S_RDY  = 0;
  localparam int S_CKNOW = 1;
  localparam int S_SDNOW = 2;
  localparam int S_CKFLG = 5;
  localparam int S_SDFLG = 6;

  localparam logic [DATA_W-1:0] CFG_MASK = 32'h03FF_FF20;

  function automatic logic [DATA_W-1:0] cr_image(logic [DATA_W-1:0] cfg, logic en,
                                                 logic busy, logic lock);
    logic [DATA_W-1:0] v;
    v = cfg & CFG_MASK;
    v[B_EN]   = en;
    v[B_CRST] = busy;
    v[B_LOCK] = lock;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] sr_image(logic rdy, logic cknow, logic sdnow,
                                                 logic ckflg, logic sdflg);
    logic [DATA_W-1:0] v;
    v = '0;
    v[S_RDY]   = rdy;
    v[S_CKNOW] = cknow;
    v[S_SDNOW] = sdnow;
    v[S_CKFLG] = ckflg;
    v[S_SDFLG] = sdflg;
    return v;
  endfunction
endpackage

// File: rtl/rng_cond_seq.sv
module rng_cond_seq #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic release_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_ARMED, SQ_RUN} sq_t;
  sq_t st;
  logic [CW-1:0] cnt;

  assign done_o = (st == SQ_RUN) && (cnt == LAST);
  assign busy_o = (st != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        SQ_IDLE:  if (arm_i) st <= SQ_ARMED;
        SQ_ARMED: if (release_i) begin st <= SQ_RUN; cnt <= '0; end
        SQ_RUN: begin
          if (done_o) st <= SQ_IDLE;
          else        cnt <= cnt + 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R4
  release_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_ARMED && release_i) |=> busy_o);
  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));
endmodule

// File: rtl/rng_prescale.sv
module rng_prescale #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  function automatic logic [CNT_W-1:0] period_mask(logic [EXP_W-1:0] e);
    logic [CNT_W-1:0] m;
    for (int i = 0; i < CNT_W; i++) m[i] = (i < int'(e));
    return m;
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  assign mask   = period_mask(exp_i);
  assign tick_o = run_i && ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // R12
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && exp_i != '0 && $stable(exp_i)) |=> !tick_o);
endmodule

// File: rtl/rng_status.sv
module rng_status (
  input  logic clk,
  input  logic rst_n,
  input  logic seed_fault_i,
  input  logic autofix_i,
  input  logic clk_fault_i,
  input  logic ck_off_i,
  input  logic cap_i,
  input  logic rd_dr_i,
  input  logic done_i,
  input  logic sr_wr_i,
  input  logic wd_sdflg_i,
  input  logic wd_ckflg_i,
  output logic rdy_o,
  output logic sdnow_o,
  output logic sdflg_o,
  output logic cknow_o,
  output logic ckflg_o
);
  logic ck_hit;
  logic sd_wclr;
  logic ck_wclr;

  assign ck_hit  = clk_fault_i & ~ck_off_i;
  assign sd_wclr = sr_wr_i & ~wd_sdflg_i;
  assign ck_wclr = sr_wr_i & ~wd_ckflg_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_o   <= 1'b0;
      sdnow_o <= 1'b0;
      sdflg_o <= 1'b0;
      cknow_o <= 1'b0;
      ckflg_o <= 1'b0;
    end else begin
      sdnow_o <= seed_fault_i | (sdnow_o & ~done_i);
      sdflg_o <= seed_fault_i | autofix_i | (sdflg_o & ~done_i & ~sd_wclr);
      cknow_o <= ck_hit;
      ckflg_o <= ck_hit | (ckflg_o & ~ck_wclr);
      rdy_o   <= (rdy_o | cap_i) & ~(rd_dr_i & rdy_o) & ~done_i & ~seed_fault_i;
    end
  end

  // R5
  seed_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_fault_i |=> (sdnow_o && sdflg_o && !rdy_o));
  // R6
  autofix_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (autofix_i && !seed_fault_i && !sdnow_o) |=> (sdflg_o && !sdnow_o));
  // R8
  rdy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_o) |-> $past(cap_i));
  // R7
  ck_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ckflg_o && !ck_wclr) |=> ckflg_o);
endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
  import rng_cr_pkg::*;
#(
  parameter int          COND_CYCLES = 16,
  parameter int          NS_W        = 18,
  parameter logic [31:0] CFG_RESET   = 32'h0030_0400,
  parameter logic [31:0] HT_RESET    = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ent_valid,
  input  logic [DATA_W-1:0] ent_word,
  input  logic              seed_fault,
  input  logic              seed_autofix,
  input  logic              clk_fault,
  output logic              ent_tick,
  output logic              cond_busy,
  output logic              data_ready,
  output logic              seed_err
);
  logic              en_q, lock_q;
  logic [DATA_W-1:0] cfg_q, ht_q, word_q;
  logic [NS_W-1:0]   ns_q;

  logic wr_any, rd_any;
  logic cr_wr, sr_wr, ns_wr, ht_wr, rd_dr;
  logic cap, seq_done;
  logic sdnow, sdflg, cknow, ckflg;

  assign wr_any = bus_sel & bus_wr;
  assign rd_any = bus_sel & ~bus_wr;
  assign cr_wr  = wr_any && (bus_addr == OFF_CR);
  assign sr_wr  = wr_any && (bus_addr == OFF_SR);
  assign ns_wr  = wr_any && (bus_addr == OFF_NS);
  assign ht_wr  = wr_any && (bus_addr == OFF_HT);
  assign rd_dr  = rd_any && (bus_addr == OFF_DR);

  assign cap = ent_valid & en_q & ~sdnow & ~cond_busy & ~data_ready;

  rng_cond_seq #(.CYCLES(COND_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .arm_i(cr_wr & bus_wdata[B_CRST]),
    .release_i(cr_wr & ~bus_wdata[B_CRST]),
    .busy_o(cond_busy), .done_o(seq_done)
  );

  rng_prescale #(.EXP_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(en_q),
    .exp_i(cfg_q[B_DIV +: DIV_W]), .tick_o(ent_tick)
  );

  rng_status u_sts (
    .clk(clk), .rst_n(rst_n),
    .seed_fault_i(seed_fault), .autofix_i(seed_autofix),
    .clk_fault_i(clk_fault), .ck_off_i(cfg_q[B_CKOFF]),
    .cap_i(cap), .rd_dr_i(rd_dr), .done_i(seq_done),
    .sr_wr_i(sr_wr), .wd_sdflg_i(bus_wdata[S_SDFLG]), .wd_ckflg_i(bus_wdata[S_CKFLG]),
    .rdy_o(data_ready), .sdnow_o(sdnow), .sdflg_o(sdflg),
    .cknow_o(cknow), .ckflg_o(ckflg)
  );

  assign seed_err = sdnow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      cfg_q  <= CFG_RESET & CFG_MASK;
      ns_q   <= '0;
      ht_q   <= HT_RESET;
      word_q <= '0;
    end else begin
      if (cr_wr) begin
        en_q <= bus_wdata[B_EN];
        if (bus_wdata[B_CRST] && !lock_q) cfg_q <= bus_wdata & CFG_MASK;
        if (bus_wdata[B_LOCK]) lock_q <= 1'b1;
      end
      if (ns_wr && !lock_q) ns_q <= bus_wdata[NS_W-1:0];
      if (ht_wr && !lock_q) ht_q <= bus_wdata;
      if (cap) word_q <= ent_word;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      unique case (bus_addr)
        OFF_CR:  bus_rdata = cr_image(cfg_q, en_q, cond_busy, lock_q);
        OFF_SR:  bus_rdata = sr_image(data_ready, cknow, sdnow, ckflg, sdflg);
        OFF_DR:  bus_rdata = (data_ready && !sdnow) ? word_q : '0;
        OFF_NS:  bus_rdata = DATA_W'(ns_q);
        OFF_HT:  bus_rdata = ht_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R10
  lock_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && ns_wr) |=> $stable(ns_q));
  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cr_wr && bus_wdata[B_CRST])) |=> $stable(cfg_q));
  // R5
  dr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dr && sdnow) |-> (bus_rdata == '0));
endmodule

// File: tb/rng_ctrl_regs_bench.sv
`timescale 1ns/100ps
module rng_ctrl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ent_valid = 1'b0;
  logic [31:0] ent_word = '0;
  logic        seed_fault = 1'b0, seed_autofix = 1'b0, clk_fault = 1'b0;
  logic        ent_tick, cond_busy, data_ready, seed_err;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rng_ctrl_regs u_rng_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ent_valid(ent_valid), .ent_word(ent_word), .seed_fault(seed_fault),
    .seed_autofix(seed_autofix), .clk_fault(clk_fault), .ent_tick(ent_tick),
    .cond_busy(cond_busy), .data_ready(data_ready), .seed_err(seed_err)
  );

  // reference model state
  bit          m_en, m_lock, m_rdy, m_sdnow, m_sdflg, m_cknow, m_ckflg;
  logic [31:0] m_cfg, m_ns, m_ht, m_word;
  int          m_phase, m_left, m_cyc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_lock = 0; m_rdy = 0; m_sdnow = 0; m_sdflg = 0; m_cknow = 0; m_ckflg = 0;
      m_cfg = 32'h0030_0400; m_ns = 0; m_ht = 0; m_word = 0;
      m_phase = 0; m_left = 0; m_cyc = 0;
    end else begin
      bit cw, sw, nw, hw, rdr, cap, fin, o_rdy, o_lock, ckon;
      cw  = bus_sel && bus_wr && bus_addr == 5'h00;
      sw  = bus_sel && bus_wr && bus_addr == 5'h04;
      nw  = bus_sel && bus_wr && bus_addr == 5'h0C;
      hw  = bus_sel && bus_wr && bus_addr == 5'h10;
      rdr = bus_sel && !bus_wr && bus_addr == 5'h08;
      o_rdy = m_rdy; o_lock = m_lock;
      ckon = clk_fault && !m_cfg[5];
      cap = ent_valid && m_en && !m_sdnow && m_phase == 0 && !m_rdy;
      fin = (m_phase == 2) && (m_left == 1);
      if (m_phase == 0 && cw && bus_wdata[30]) m_phase = 1;
      else if (m_phase == 1 && cw && !bus_wdata[30]) begin m_phase = 2; m_left = 16; end
      else if (m_phase == 2) begin m_left--; if (m_left == 0) m_phase = 0; end
      if (cap) begin m_rdy = 1; m_word = ent_word; end
      if (rdr && o_rdy) m_rdy = 0;
      if (fin || seed_fault) m_rdy = 0;
      if (fin) begin m_sdnow = 0; m_sdflg = 0; end
      if (sw && !bus_wdata[6]) m_sdflg = 0;
      if (sw && !bus_wdata[5]) m_ckflg = 0;
      if (seed_fault) m_sdnow = 1;
      if (seed_fault || seed_autofix) m_sdflg = 1;
      if (ckon) m_ckflg = 1;
      m_cknow = ckon;
      if (cw) begin
        m_en = bus_wdata[2];
        if (bus_wdata[30] && !o_lock) m_cfg = bus_wdata & 32'h03FF_FF20;
        if (bus_wdata[31]) m_lock = 1;
      end
      if (nw && !o_lock) m_ns = bus_wdata & 32'h0003_FFFF;
      if (hw && !o_lock) m_ht = bus_wdata;
      m_cyc++;
    end
  end

  function automatic logic [31:0] m_read(logic [4:0] a);
    case (a)
      5'h00: return m_cfg | (32'(m_en) << 2) | (32'(m_phase != 0) << 30) | (32'(m_lock) << 31);
      5'h04: return (32'(m_sdflg) << 6) | (32'(m_ckflg) << 5) | (32'(m_sdnow) << 2) |
                    (32'(m_cknow) << 1) | 32'(m_rdy);
      5'h08: return (m_rdy && !m_sdnow) ? m_word : 32'h0;
      5'h0C: return m_ns;
      5'h10: return m_ht;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (rst_n) begin
      int mask;
      mask = (1 << m_cfg[19:16]) - 1;
      check("R4 cond_busy", 32'(cond_busy), 32'(m_phase != 0));
      check("R8 data_ready", 32'(data_ready), 32'(m_rdy));
      check("R5 seed_err", 32'(seed_err), 32'(m_sdnow));
      check("R12 ent_tick", 32'(ent_tick), 32'(m_en && ((m_cyc & mask) == mask)));
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(string tag, logic [4:0] a, logic [31:0] fixed, bit use_fixed);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 check(tag, bus_rdata, use_fixed ? fixed : m_read(a));
    @(posedge clk); #1 bus_sel = 0;
  endtask

  task automatic push(logic [31:0] w);
    @(negedge clk); ent_valid = 1; ent_word = w;
    @(posedge clk); #1 ent_valid = 0;
  endtask

  task automatic recondition(logic [31:0] cfg);
    wr(5'h00, cfg | 32'h4000_0000);
    wr(5'h00, cfg & ~32'h4000_0000);
    repeat (20) @(posedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #50000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values, fixed constants
    rd("R1 cr reset", 5'h00, 32'h0030_0400, 1);
    rd("R1 sr reset", 5'h04, 32'h0, 1);
    rd("R1 dr reset", 5'h08, 32'h0, 1);
    rd("R2 ns reset", 5'h0C, 32'h0, 1);
    rd("R2 ht reset", 5'h10, 32'h0, 1);
    // R3 config ignored without reset bit, enable taken
    wr(5'h00, 32'h0000_0F24);
    rd("R3 cfg kept en set", 5'h00, 32'h0030_0404, 1);
    // R4 arm then release
    wr(5'h00, 32'h4002_0A04);
    rd("R4 armed reads busy", 5'h00, 32'h4002_0A04, 1);
    wr(5'h00, 32'h0002_0A04);
    rd("R4 running reads busy", 5'h00, 32'h4002_0A04, 1);
    repeat (20) @(posedge clk);
    rd("R4 done clears bit", 5'h00, 32'h0002_0A04, 1);
    // R8 R9 capture and read
    push(32'hA5A5_0001);
    rd("R8 ready after capture", 5'h04, 32'h1, 1);
    push(32'h0000_1234);
    rd("R9 held word", 5'h08, 32'hA5A5_0001, 1);
    rd("R9 empty read zero", 5'h08, 32'h0, 1);
    // R5 seed fault
    push(32'h5555_AAAA);
    @(negedge clk); seed_fault = 1; @(posedge clk); #1 seed_fault = 0;
    rd("R5 both seed bits", 5'h04, 32'h44, 1);
    rd("R5 data zero", 5'h08, 32'h0, 1);
    push(32'h1111_2222);
    rd("R5 no capture", 5'h04, 32'h44, 1);
    recondition(32'h0002_0A04);
    rd("R4 seed cleared", 5'h04, 32'h0, 1);
    push(32'h7777_0003);
    rd("R8 capture resumes", 5'h08, 32'h7777_0003, 1);
    // R6 self-fixed fault
    @(negedge clk); seed_autofix = 1; @(posedge clk); #1 seed_autofix = 0;
    rd("R6 flag only", 5'h04, 32'h40, 1);
    wr(5'h04, 32'h7F);
    rd("R6 write one ignored", 5'h04, 32'h40, 1);
    wr(5'h04, 32'h0);
    rd("R6 write zero clears", 5'h04, 32'h0, 1);
    // R7 clock fault
    @(negedge clk); clk_fault = 1;
    repeat (2) @(posedge clk);
    rd("R7 now and flag", 5'h04, 32'h22, 1);
    @(negedge clk); clk_fault = 0;
    @(posedge clk);
    rd("R7 flag sticky", 5'h04, 32'h20, 1);
    wr(5'h04, 32'h0);
    rd("R7 flag cleared", 5'h04, 32'h0, 1);
    recondition(32'h0002_0A24);
    @(negedge clk); clk_fault = 1; repeat (2) @(posedge clk); #1 clk_fault = 0;
    rd("R7 disabled ignores", 5'h04, 32'h0, 1);
    // R11
    wr(5'h0C, 32'hFFFF_FFFF);
    rd("R11 ns width", 5'h0C, 32'h0003_FFFF, 1);
    wr(5'h10, 32'hDEAD_BEEF);
    rd("R11 ht full", 5'h10, 32'hDEAD_BEEF, 1);
    // R10 lock
    recondition(32'h8001_0B04);
    rd("R10 lock and cfg", 5'h00, 32'h8001_0B04, 1);
    recondition(32'h0003_0C04);
    rd("R10 cfg frozen", 5'h00, 32'h8001_0B04, 1);
    wr(5'h0C, 32'h0);
    rd("R10 ns frozen", 5'h0C, 32'h0003_FFFF, 1);
    wr(5'h10, 32'h0);
    rd("R10 ht frozen", 5'h10, 32'hDEAD_BEEF, 1);
    wr(5'h00, 32'h0);
    rd("R10 enable still writable", 5'h00, 32'h8001_0B00, 1);
    // R12 exponent 0 via model after system reset
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    wr(5'h00, 32'h0000_0004);
    repeat (10) @(posedge clk);
    rd("R12 model cr", 5'h00, 32'h0, 0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule